// File: doc/BRIEF.md
# Register-Initialisation AXI4 Write Master

This block is a write-only AXI4 master that plays a short, fixed script of single-beat 32-bit register writes. It waits in idle for a start pulse. After the pulse it spends one cycle preparing, then issues each scripted write in turn. For each write it waits for the write response before it moves to the next entry. After the final response it parks in a terminal state until reset. The typical use is to bring a handful of configuration registers into a known state right after power-up, with no processor involved.

The master follows the address and data handshakes as two independent events. The slave may take the address first, the data first, or both in the same cycle. A failed write response does not stop the script, but it leaves a sticky error indication.

Top module: `axi_init_writer`

## Requirements
- R1: While reset is held, and directly after it, awvalid, wvalid, bready, busy, done and error are all low.
- R2: A start seen high in idle moves the master to a single preparation cycle. busy goes high after the edge that samples start. awvalid and wvalid first go high one cycle later.
- R3: Exactly three writes are issued, in this order: data 0x0000FE01 to address 0xE000A204, data 0x0000FE01 to 0xE000A208, then data 0x00000001 to 0xE000A040.
- R4: When awready and wready are both high in the same cycle, both handshakes complete on that edge and the master goes straight to the response phase. With an always-ready slave whose response comes at once, done rises on the eighth edge counted from the edge that samples start.
- R5: If only the address is accepted, the next cycle has awvalid low and wvalid still high, until wready arrives.
- R6: If only the data is accepted, the next cycle has wvalid low and awvalid still high, until awready arrives.
- R7: While awvalid is high and awready is low, awvalid and awaddr hold into the next cycle. While wvalid is high and wready is low, wvalid and wdata hold.
- R8: Whenever awvalid is high, awlen is 0, awsize is 3'b010 (four bytes), awburst is 2'b01 (incrementing), wstrb is 4'hF and wlast is 1.
- R9: bready is high only in the response phase, and never together with awvalid or wvalid. No new address is offered until the previous write has received its response.
- R10: A response with bresp other than 2'b00 sets error. error then stays high until reset.
- R11: After the third response, done is high and busy is low, and both stay that way. A later start pulse issues no further write.
- R12: After reset, none of the outputs awvalid, awaddr, wvalid, wdata, bready, busy, done or error is ever unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| start | input | 1 | Launches the script when seen high in idle |
| awaddr | output | 32 | Write address |
| awlen | output | 8 | Burst length minus one, always 0 |
| awsize | output | 3 | Bytes per beat, as a power of two |
| awburst | output | 2 | Burst type, incrementing |
| awvalid | output | 1 | Address valid |
| awready | input | 1 | Address accepted by the slave |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Byte strobes, all set |
| wlast | output | 1 | Last beat, always set |
| wvalid | output | 1 | Data valid |
| wready | input | 1 | Data accepted by the slave |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Master ready for the response |
| busy | output | 1 | Script running |
| done | output | 1 | Script finished |
| error | output | 1 | Sticky flag: some response was not OKAY |

## Verification
The assertions assume a slave that behaves as AXI4 requires. It raises bvalid only after it has accepted both the address and the data of a write. It holds bvalid and bresp until bready takes them. It drives no unknown values on its ready and response lines once reset is released. The bench slave drives all of its outputs half a cycle away from the sampling edge. It counts its own cycles of delay before it raises awready, wready or bvalid. It lowers bvalid on the cycle after the response handshake. In this way every stimulus pattern, fixed or drawn at random, stays inside those assumptions.

// File: rtl/axi_init_pkg.sv
`timescale 1ns/1ps
package axi_init_pkg;

  localparam int unsigned SCRIPT_LEN = 3;

  // entry 0 is the first write issued
  localparam logic [SCRIPT_LEN-1:0][31:0] SCRIPT_ADDR =
    {32'hE000_A040, 32'hE000_A208, 32'hE000_A204};
  localparam logic [SCRIPT_LEN-1:0][31:0] SCRIPT_DATA =
    {32'h0000_0001, 32'h0000_FE01, 32'h0000_FE01};

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;

  // 3-bit binary encoding; code 7 is unused and falls back to idle
  typedef enum logic [2:0] {
    WS_IDLE   = 3'd0,
    WS_PREP   = 3'd1,
    WS_BOTH   = 3'd2,
    WS_DATA   = 3'd3,
    WS_ADDR   = 3'd4,
    WS_RESP   = 3'd5,
    WS_FINAL  = 3'd6
  } wr_state_e;

endpackage

// File: rtl/axi_init_script.sv
`timescale 1ns/1ps
module axi_init_script
  import axi_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_WR   = SCRIPT_LEN,
  localparam int unsigned IDX_W = (N_WR > 1) ? $clog2(N_WR) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  logic [N_WR-1:0][ADDR_W-1:0] addr_tab;
  logic [N_WR-1:0][DATA_W-1:0] data_tab;

  for (genvar g = 0; g < N_WR; g++) begin : g_entry
    assign addr_tab[g] = ADDR_W'(SCRIPT_ADDR[g]);
    assign data_tab[g] = DATA_W'(SCRIPT_DATA[g]);
  end

  always_comb begin
    addr = '0;
    data = '0;
    for (int i = 0; i < N_WR; i++) begin
      if (idx == IDX_W'(i)) begin
        addr = addr_tab[i];
        data = data_tab[i];
      end
    end
  end

endmodule

// File: rtl/axi_init_fsm.sv
`timescale 1ns/1ps
module axi_init_fsm
  import axi_init_pkg::*;
#(
  parameter int unsigned N_WR   = SCRIPT_LEN,
  localparam int unsigned IDX_W = (N_WR > 1) ? $clog2(N_WR) : 1,
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WR - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             awready,
  input  logic             wready,
  input  logic             bvalid,
  output wr_state_e        state,
  output logic [IDX_W-1:0] idx,
  output logic             resp_fire
);

  wr_state_e        state_q, state_nx;
  logic [IDX_W-1:0] idx_q;
  logic             idx_en;

  // next-state logic: the only process that decides the state
  always_comb begin
    state_nx = state_q;
    idx_en   = 1'b0;
    case (state_q)
      WS_IDLE:  if (start) state_nx = WS_PREP;
      WS_PREP:  state_nx = WS_BOTH;
      WS_BOTH: begin
        if (awready && wready) state_nx = WS_RESP;
        else if (awready)      state_nx = WS_DATA;
        else if (wready)       state_nx = WS_ADDR;
      end
      WS_DATA:  if (wready)  state_nx = WS_RESP;
      WS_ADDR:  if (awready) state_nx = WS_RESP;
      WS_RESP: begin
        if (bvalid) begin
          if (idx_q == LAST_IDX) begin
            state_nx = WS_FINAL;
          end else begin
            state_nx = WS_BOTH;
            idx_en   = 1'b1;
          end
        end
      end
      WS_FINAL: state_nx = WS_FINAL;
      default:  state_nx = WS_IDLE;
    endcase
  end

  // register process: the only process that writes state_q
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_q + 1'b1;
  end

  assign state     = state_q;
  assign idx       = idx_q;
  assign resp_fire = (state_q == WS_RESP) && bvalid;

endmodule

// File: rtl/axi_init_err.sv
`timescale 1ns/1ps
module axi_init_err
  import axi_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resp_fire,
  input  logic [1:0] bresp,
  output logic       err
);

  logic err_q;
  logic err_set;

  assign err_set = resp_fire && (bresp != RESP_OKAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign err = err_q;

endmodule

// File: rtl/axi_init_writer.sv
`timescale 1ns/1ps
module axi_init_writer
  import axi_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic              busy,
  output logic              done,
  output logic              error
);

  localparam int unsigned N_WR  = SCRIPT_LEN;
  localparam int unsigned IDX_W = (N_WR > 1) ? $clog2(N_WR) : 1;
  localparam logic [2:0]  SIZE_CODE = 3'($clog2(STRB_W));

  wr_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             resp_fire;

  axi_init_fsm #(.N_WR(N_WR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .awready   (awready),
    .wready    (wready),
    .bvalid    (bvalid),
    .state     (state),
    .idx       (idx),
    .resp_fire (resp_fire)
  );

  axi_init_script #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_WR(N_WR)) u_script (
    .idx  (idx),
    .addr (awaddr),
    .data (wdata)
  );

  axi_init_err u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .resp_fire (resp_fire),
    .bresp     (bresp),
    .err       (error)
  );

  // channel valids and status decoded from the registered state
  assign awvalid = (state == WS_BOTH) || (state == WS_ADDR);
  assign wvalid  = (state == WS_BOTH) || (state == WS_DATA);
  assign bready  = (state == WS_RESP);
  assign done    = (state == WS_FINAL);
  assign busy    = (state != WS_IDLE) && (state != WS_FINAL);

  assign awlen   = 8'd0;
  assign awsize  = SIZE_CODE;
  assign awburst = BURST_INCR;
  assign wstrb   = '1;
  assign wlast   = 1'b1;

endmodule

// File: rtl/axi_init_writer_chk.sv
`timescale 1ns/1ps
module axi_init_writer_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] awaddr,
  input logic [7:0]        awlen,
  input logic [2:0]        awsize,
  input logic [1:0]        awburst,
  input logic              awvalid,
  input logic              awready,
  input logic [DATA_W-1:0] wdata,
  input logic [STRB_W-1:0] wstrb,
  input logic              wlast,
  input logic              wvalid,
  input logic              wready,
  input logic [1:0]        bresp,
  input logic              bvalid,
  input logic              bready,
  input logic              busy,
  input logic              done,
  input logic              error
);

  a_r2_prep_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !awvalid && !wvalid);

  a_r5_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awready && wvalid && !wready |=> !awvalid && wvalid);

  a_r6_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && wready && awvalid && !awready |=> awvalid && !wvalid);

  a_r7_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));

  a_r7_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata));

  a_r8_fixed_attr: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> awlen == 8'd0 && awsize == 3'b010 && awburst == 2'b01
                && wstrb == '1 && wlast);

  a_r9_resp_alone: assert property (@(posedge clk) disable iff (!rst_n)
    bready |-> !awvalid && !wvalid);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(bvalid && bready && bresp != 2'b00));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  a_r11_final_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !busy && !awvalid && !wvalid);

  a_r12_no_x: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({awvalid, wvalid, bready, busy, done, error, awaddr, wdata}));

endmodule

bind axi_init_writer axi_init_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .awaddr(awaddr), .awlen(awlen),
  .awsize(awsize), .awburst(awburst), .awvalid(awvalid), .awready(awready),
  .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
  .bresp(bresp), .bvalid(bvalid), .bready(bready), .busy(busy), .done(done),
  .error(error)
);

// File: tb/axi_init_writer_bench.sv
`timescale 1ns/1ps
module axi_init_writer_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic        awvalid;
  logic        awready;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic        wlast;
  logic        wvalid;
  logic        wready;
  logic [1:0]  bresp;
  logic        bvalid;
  logic        bready;
  logic        busy;
  logic        done;
  logic        error;

  axi_init_writer u_axi_init_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready), .busy(busy), .done(done),
    .error(error)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [31:0] exp_addr [3];
  logic [31:0] exp_data [3];
  initial begin
    exp_addr[0] = 32'hE000A204; exp_data[0] = 32'h0000FE01;
    exp_addr[1] = 32'hE000A208; exp_data[1] = 32'h0000FE01;
    exp_addr[2] = 32'hE000A040; exp_data[2] = 32'h00000001;
  end

  // slave configuration, written only by the test sequence
  int aw_delay = 0, w_delay = 0, b_delay = 0;
  bit rand_mode = 0;
  int err_at = -1;

  // monitor state, written only by the posedge monitor
  logic [31:0] aw_log [8];
  logic [31:0] w_log  [8];
  int aw_cnt, w_cnt, b_cnt;
  int aw_first, w_first;
  int stab_err, order_err, attr_err, resp_err, x_err;
  bit got_aw, got_w, bhs;
  bit pv_awv, pv_awr, pv_wv, pv_wr;
  logic [31:0] pv_addr, pv_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      aw_cnt = 0; w_cnt = 0; b_cnt = 0; aw_first = 0; w_first = 0;
      stab_err = 0; order_err = 0; attr_err = 0; resp_err = 0; x_err = 0;
      got_aw = 0; got_w = 0; bhs = 0;
      pv_awv = 0; pv_awr = 0; pv_wv = 0; pv_wr = 0; pv_addr = '0; pv_data = '0;
    end else begin
      if ($isunknown({awvalid, wvalid, bready, busy, done, error, awaddr, wdata})) x_err++;
      if (pv_awv && !pv_awr && (!awvalid || awaddr != pv_addr)) stab_err++;
      if (pv_wv && !pv_wr && (!wvalid || wdata != pv_data)) stab_err++;
      if (pv_awv && pv_awr && pv_wv && !pv_wr) begin
        aw_first++;
        if (awvalid || !wvalid) order_err++;
      end
      if (pv_wv && pv_wr && pv_awv && !pv_awr) begin
        w_first++;
        if (!awvalid || wvalid) order_err++;
      end
      if (awvalid && (awlen != 8'd0 || awsize != 3'b010 || awburst != 2'b01 ||
                      wstrb != 4'hF || !wlast)) attr_err++;
      if (bready && (awvalid || wvalid)) resp_err++;
      if (bvalid && !bready) resp_err++;
      if (awvalid && awready) begin
        if (aw_cnt != b_cnt) resp_err++;
        if (aw_cnt < 8) aw_log[aw_cnt] = awaddr;
        aw_cnt++;
        got_aw = 1;
      end
      if (wvalid && wready) begin
        if (w_cnt < 8) w_log[w_cnt] = wdata;
        w_cnt++;
        got_w = 1;
      end
      bhs = bvalid && bready;
      if (bhs) begin
        got_aw = 0; got_w = 0; b_cnt++;
      end
      pv_awv = awvalid; pv_awr = awready; pv_wv = wvalid; pv_wr = wready;
      pv_addr = awaddr; pv_data = wdata;
    end
  end

  // slave model: drives its outputs on the falling edge
  int aw_wait, w_wait, b_wait, aw_lim, w_lim, b_lim;
  always @(negedge clk) begin
    if (!rst_n) begin
      awready = 0; wready = 0; bvalid = 0; bresp = 2'b00;
      aw_wait = 0; w_wait = 0; b_wait = 0; aw_lim = 0; w_lim = 0; b_lim = 0;
    end else begin
      if (awvalid && !got_aw) begin
        if (aw_wait == 0) aw_lim = rand_mode ? int'($urandom_range(0, 4)) : aw_delay;
        awready = (aw_wait >= aw_lim);
        aw_wait++;
      end else begin
        awready = 0; aw_wait = 0;
      end
      if (wvalid && !got_w) begin
        if (w_wait == 0) w_lim = rand_mode ? int'($urandom_range(0, 4)) : w_delay;
        wready = (w_wait >= w_lim);
        w_wait++;
      end else begin
        wready = 0; w_wait = 0;
      end
      if (bhs) begin
        bvalid = 0; b_wait = 0; bresp = 2'b00;
      end else if (got_aw && got_w && !bvalid) begin
        if (b_wait == 0) b_lim = rand_mode ? int'($urandom_range(0, 4)) : b_delay;
        if (b_wait >= b_lim) begin
          bvalid = 1;
          bresp  = (b_cnt == err_at) ? 2'b10 : 2'b00;
        end
        b_wait++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 1;
    while (!done && cycles < 400) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic check_run(input string tag, input bit exp_err);
    chk(aw_cnt == 3, "R3", {tag, " address count"}, aw_cnt, 3);
    chk(w_cnt == 3, "R3", {tag, " data count"}, w_cnt, 3);
    for (int i = 0; i < 3; i++) begin
      chk(aw_log[i] == exp_addr[i], "R3", {tag, " address entry"}, aw_log[i], exp_addr[i]);
      chk(w_log[i] == exp_data[i], "R3", {tag, " data entry"}, w_log[i], exp_data[i]);
    end
    chk(stab_err == 0, "R7", {tag, " hold while not ready"}, stab_err, 0);
    chk(attr_err == 0, "R8", {tag, " fixed attributes"}, attr_err, 0);
    chk(resp_err == 0, "R9", {tag, " response phase"}, resp_err, 0);
    chk(x_err == 0, "R12", {tag, " unknown output"}, x_err, 0);
    chk(error == exp_err, "R10", {tag, " error flag"}, error, exp_err);
    chk(done && !busy, "R11", {tag, " final state"}, {done, busy}, 2'b10);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 0; start = 0;
    @(negedge clk);
    chk({awvalid, wvalid, bready, busy, done, error} == 6'b0, "R1", "during reset",
        {awvalid, wvalid, bready, busy, done, error}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({awvalid, wvalid, bready, busy, done, error} == 6'b0, "R1", "after reset",
        {awvalid, wvalid, bready, busy, done, error}, 0);
  endtask

  task automatic t_same_cycle();
    int cyc;
    aw_delay = 0; w_delay = 0; b_delay = 0; rand_mode = 0; err_at = -1;
    do_reset();
    pulse_start();
    chk(busy && !awvalid && !wvalid, "R2", "preparation cycle",
        {busy, awvalid, wvalid}, 3'b100);
    @(negedge clk);
    chk(awvalid && wvalid, "R2", "first write offered", {awvalid, wvalid}, 2'b11);
    wait_done(cyc);
    chk(cyc == 7, "R4", "cycles to done after preparation", cyc, 7);
    chk(aw_first == 0 && w_first == 0, "R4", "no split handshakes",
        aw_first + w_first, 0);
    check_run("same-cycle", 1'b0);
  endtask

  task automatic t_addr_first();
    int cyc;
    aw_delay = 0; w_delay = 2; b_delay = 1; rand_mode = 0; err_at = -1;
    do_reset();
    pulse_start();
    wait_done(cyc);
    chk(aw_first == 3, "R5", "address-first writes", aw_first, 3);
    chk(order_err == 0, "R5", "valids after address-only", order_err, 0);
    check_run("address-first", 1'b0);
  endtask

  task automatic t_data_first();
    int cyc;
    aw_delay = 2; w_delay = 0; b_delay = 0; rand_mode = 0; err_at = -1;
    do_reset();
    pulse_start();
    wait_done(cyc);
    chk(w_first == 3, "R6", "data-first writes", w_first, 3);
    chk(order_err == 0, "R6", "valids after data-only", order_err, 0);
    check_run("data-first", 1'b0);
  endtask

  task automatic t_error();
    int cyc;
    aw_delay = 1; w_delay = 1; b_delay = 2; rand_mode = 0; err_at = 1;
    do_reset();
    pulse_start();
    cyc = 0;
    while (b_cnt < 1 && cyc < 100) begin @(negedge clk); cyc++; end
    chk(!error, "R10", "error before bad response", error, 0);
    wait_done(cyc);
    check_run("error", 1'b1);
    err_at = -1;
    do_reset();
    chk(!error, "R10", "error cleared by reset", error, 0);
  endtask

  task automatic t_final_hold();
    int cyc;
    aw_delay = 0; w_delay = 0; b_delay = 0; rand_mode = 0; err_at = -1;
    do_reset();
    pulse_start();
    wait_done(cyc);
    pulse_start();
    repeat (10) @(negedge clk);
    chk(aw_cnt == 3 && w_cnt == 3, "R11", "writes after restart attempt", aw_cnt, 3);
    chk(done && !busy, "R11", "still final", {done, busy}, 2'b10);
  endtask

  task automatic t_random();
    int cyc;
    rand_mode = 1; err_at = -1;
    for (int r = 0; r < 4; r++) begin
      do_reset();
      pulse_start();
      wait_done(cyc);
      check_run("random", 1'b0);
      chk(order_err == 0, "R5", "random handshake order", order_err, 0);
    end
    rand_mode = 0;
  endtask

  initial begin
    rst_n = 0; start = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_same_cycle();
    t_addr_first();
    t_data_first();
    t_error();
    t_final_hold();
    t_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule